// File: doc/BRIEF.md
# SPI Flash Dual-Read Controller

This block is the host end of a four-wire serial link to a small flash device. It serves read requests only. A request is a start pulse with a byte address, a byte count and a mode bit. The block drops chip select, shifts out a read opcode and a three-byte address, and runs eight dummy clocks. It then collects the requested bytes and hands them to the user one per valid strobe. A done pulse closes the request.

There are two read modes. In the one-line mode the device returns one bit per clock on its output line. In the two-line mode the controller releases its own output line after the dummy clocks. The device then drives both lines, two bits per clock. The serial clock is made from the system clock with a divider that the user sets for each request. A parameter selects whether the serial clock idles low or high. A request that lies outside the 64 KiB array is refused without any bus activity.

Top module: `sfrd_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o sits at its idle level (0 when CPOL=0, 1 when CPOL=1), and busy_o, valid_o and done_o are 0.
- R2: Whenever cs_n_o falls, rises or is high, sclk_o equals the idle level set by CPOL.
- R3: A transfer starts with opcode 0Bh (dual_i=0) or 3Bh (dual_i=1), followed by the 24-bit address. Bits are sent most significant first. Each bit is placed on mosi_o while sclk_o is low and is held through the rising edge.
- R4: One transfer of N bytes has exactly 40 + 8·N rising sclk_o edges in one-line mode, and 40 + 4·N in two-line mode. These are 32 header clocks and 8 dummy clocks, then the data clocks.
- R5: In one-line mode the controller samples miso_i at each rising data edge, most significant bit first. Each completed byte appears on data_o with a one-cycle valid_o pulse, in ascending address order.
- R6: In two-line mode each rising data edge captures a bit pair. miso_i carries bits 7, 5, 3 and 1. mosi_i carries bits 6, 4, 2 and 0. One byte takes four clocks.
- R7: In two-line mode mosi_oe_o is 0 from the first data clock until chip select rises. In one-line mode it stays 1.
- R8: Each accepted request ends with a single done_o pulse with busy_o low. After cs_n_o rises it stays high for at least 2 system cycles before it may fall again.
- R9: A request with len_i = 0, or with addr_i + len_i > 10000h, makes done_o and err_o pulse together one cycle after start. cs_n_o never falls for it. A request whose last byte is at FFFFh is accepted.
- R10: Every high and low half of sclk_o lasts max(div_i, 2) system cycles, with div_i sampled at start.
- R11: A start pulse while busy_o is 1 is ignored. The running transfer delivers exactly its own byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| addr_i | input | 24 | First byte address |
| len_i | input | 17 | Byte count |
| dual_i | input | 1 | 1 selects two-line data return |
| div_i | input | 4 | System cycles per serial half clock (values below 2 act as 2) |
| busy_o | output | 1 | Request in progress |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | data_o holds a new byte this cycle |
| done_o | output | 1 | Request finished |
| err_o | output | 1 | Request refused (range), with done_o |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Host-to-device line value |
| mosi_oe_o | output | 1 | Drive enable for the host-to-device line |
| mosi_i | input | 1 | Host-to-device line as seen at the pad (device data in two-line mode) |
| miso_i | input | 1 | Device-to-host line |

## Verification
The properties assume that start_i is a synchronous pulse and that addr_i, len_i, dual_i and div_i do not change while a request is pending. They also assume the device drives the shared line only after the host has released it. The bench changes the request inputs only between requests. Its only overlapping start comes while busy_o is high, and it keeps the same inputs. Its inline flash model enables its line drive only after it has decoded the full header and dummy count. Two instances, one per clock polarity, receive the same stimulus, so both edge disciplines are exercised against one expectation.

// File: rtl/sfrd_pkg.sv
package sfrd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_CMD,
        S_DUMMY,
        S_DATA,
        S_TRAIL,
        S_GAP
    } sfrd_st_e;

    localparam logic [7:0] OPC_FAST_1 = 8'h0B;
    localparam logic [7:0] OPC_FAST_2 = 8'h3B;

    function automatic logic [7:0] sfrd_opcode(input logic two_line);
        return two_line ? OPC_FAST_2 : OPC_FAST_1;
    endfunction

endpackage

// File: rtl/sfrd_range.sv
module sfrd_range #(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = 17,
    parameter int MEM_BYTES = 65536
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    output logic              ok_o
);
    localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

    logic [SUM_W-1:0] end_excl;

    always_comb begin
        end_excl = SUM_W'(addr_i) + SUM_W'(len_i);
        ok_o     = (len_i != '0) && (end_excl <= SUM_W'(MEM_BYTES));
    end
endmodule

// File: rtl/sfrd_halftick.sv
module sfrd_halftick #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            if (cnt_q == DIV_W'(div_i - 1'b1)) begin
                tick_o = 1'b1;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sfrd_ctrl.sv
module sfrd_ctrl
    import sfrd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int LEN_W      = 17,
    parameter int DIV_W      = 4,
    parameter int MEM_BYTES  = 65536,
    parameter int CPOL       = 0,
    parameter int DUMMY_CLKS = 8,
    parameter int GAP_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              dual_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              busy_o,
    output logic [7:0]        data_o,
    output logic              valid_o,
    output logic              done_o,
    output logic              err_o,
    output logic              sclk_o,
    output logic              cs_n_o,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              mosi_i,
    input  logic              miso_i
);
    localparam int   HDR_BITS = 8 + ADDR_W;
    localparam int   MAXCNT   = (HDR_BITS > DUMMY_CLKS) ? HDR_BITS : DUMMY_CLKS;
    localparam int   BIT_W    = $clog2(MAXCNT + GAP_CYC + 1);
    localparam logic IDLE_LVL = (CPOL != 0);
    localparam logic [BIT_W-1:0] LAST_1 = BIT_W'(7);
    localparam logic [BIT_W-1:0] LAST_2 = BIT_W'(3);

    typedef struct packed {
        sfrd_st_e            st;
        logic                ph;
        logic [BIT_W-1:0]    bits;
        logic [HDR_BITS-1:0] sh;
        logic [7:0]          rx;
        logic [LEN_W-1:0]    left;
        logic                dual;
        logic [DIV_W-1:0]    div;
        logic                sclk;
        logic                csn;
        logic                mosi;
        logic                oe;
        logic [7:0]          data;
        logic                valid;
        logic                done;
        logic                err;
    } regs_t;

    regs_t q, n;
    logic  range_ok, tick, tick_clr, tick_run;
    logic  byte_end;
    logic [7:0] rx_next;

    sfrd_range #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .MEM_BYTES(MEM_BYTES)
    ) u_range (
        .addr_i(addr_i),
        .len_i (len_i),
        .ok_o  (range_ok)
    );

    assign tick_run = (q.st == S_LEAD) || (q.st == S_CMD) || (q.st == S_DUMMY) ||
                      (q.st == S_DATA) || (q.st == S_TRAIL);

    sfrd_halftick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tick_clr),
        .run_i (tick_run),
        .div_i (q.div),
        .tick_o(tick)
    );

    always_comb begin
        n        = q;
        n.valid  = 1'b0;
        n.done   = 1'b0;
        n.err    = 1'b0;
        tick_clr = 1'b0;
        byte_end = q.dual ? (q.bits == LAST_2) : (q.bits == LAST_1);
        rx_next  = q.dual ? {q.rx[5:0], miso_i, mosi_i} : {q.rx[6:0], miso_i};

        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    if (!range_ok) begin
                        n.done = 1'b1;
                        n.err  = 1'b1;
                    end else begin
                        n.st     = S_LEAD;
                        n.csn    = 1'b0;
                        n.sh     = {sfrd_opcode(dual_i), addr_i};
                        n.left   = len_i;
                        n.dual   = dual_i;
                        n.div    = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
                        n.oe     = 1'b1;
                        n.mosi   = 1'b0;
                        n.sclk   = IDLE_LVL;
                        tick_clr = 1'b1;
                    end
                end
            end

            S_LEAD: begin
                if (tick) begin
                    n.st   = S_CMD;
                    n.ph   = 1'b0;
                    n.sclk = 1'b0;
                    n.bits = '0;
                    n.mosi = q.sh[HDR_BITS-1];
                end
            end

            S_TRAIL: begin
                if (tick) begin
                    n.st   = S_GAP;
                    n.csn  = 1'b1;
                    n.oe   = 1'b1;
                    n.mosi = 1'b0;
                    n.bits = '0;
                end
            end

            S_GAP: begin
                n.bits = q.bits + 1'b1;
                if (q.bits == BIT_W'(GAP_CYC - 1)) begin
                    n.st   = S_IDLE;
                    n.bits = '0;
                    n.done = 1'b1;
                end
            end

            default: begin
                if (tick) begin
                    if (!q.ph) begin
                        n.ph   = 1'b1;
                        n.sclk = 1'b1;
                        if (q.st == S_DATA) begin
                            n.rx = rx_next;
                            if (byte_end) begin
                                n.valid = 1'b1;
                                n.data  = rx_next;
                                n.left  = q.left - 1'b1;
                            end
                        end
                    end else begin
                        n.ph   = 1'b0;
                        n.sclk = 1'b0;
                        n.bits = q.bits + 1'b1;
                        case (q.st)
                            S_CMD: begin
                                if (q.bits == BIT_W'(HDR_BITS - 1)) begin
                                    n.st   = S_DUMMY;
                                    n.bits = '0;
                                    n.mosi = 1'b0;
                                end else begin
                                    n.sh   = q.sh << 1;
                                    n.mosi = q.sh[HDR_BITS-2];
                                end
                            end
                            S_DUMMY: begin
                                if (q.bits == BIT_W'(DUMMY_CLKS - 1)) begin
                                    n.st   = S_DATA;
                                    n.bits = '0;
                                    n.oe   = !q.dual;
                                end
                            end
                            S_DATA: begin
                                if (byte_end) begin
                                    n.bits = '0;
                                    if (q.left == '0) begin
                                        if (IDLE_LVL == 1'b0) begin
                                            n.st = S_TRAIL;
                                        end else begin
                                            n.st   = S_GAP;
                                            n.sclk = 1'b1;
                                            n.csn  = 1'b1;
                                            n.oe   = 1'b1;
                                        end
                                    end
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= IDLE_LVL;
            q.csn  <= 1'b1;
            q.oe   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy_o    = (q.st != S_IDLE);
    assign data_o    = q.data;
    assign valid_o   = q.valid;
    assign done_o    = q.done;
    assign err_o     = q.err;
    assign sclk_o    = q.sclk;
    assign cs_n_o    = q.csn;
    assign mosi_o    = q.mosi;
    assign mosi_oe_o = q.oe;
endmodule

// File: rtl/sfrd_ctrl_chk.sv
module sfrd_ctrl_chk #(
    parameter int CPOL = 0
) (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic valid_o,
    input logic done_o,
    input logic err_o,
    input logic sclk_o,
    input logic cs_n_o,
    input logic mosi_o
);
    localparam logic IDLE_LVL = (CPOL != 0);

    AST_CS_FALL_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> sclk_o == IDLE_LVL); // R2
    AST_CS_RISE_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> sclk_o == IDLE_LVL); // R2
    AST_IDLE_CLK_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o == IDLE_LVL); // R2
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R3
    AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !cs_n_o); // R5
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && cs_n_o)); // R8
    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && cs_n_o && $past(cs_n_o))); // R9
endmodule

bind sfrd_ctrl sfrd_ctrl_chk #(.CPOL(CPOL)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy_o (busy_o),
    .valid_o(valid_o),
    .done_o (done_o),
    .err_o  (err_o),
    .sclk_o (sclk_o),
    .cs_n_o (cs_n_o),
    .mosi_o (mosi_o)
);

// File: tb/sfrd_ctrl_bench.sv
`timescale 1ns/1ps

module sfrd_flash_model #(
    parameter int CPOL = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        busy_i,
    input  logic [23:0] addr_i,
    input  logic [16:0] len_i,
    input  logic        dual_i,
    input  logic [3:0]  div_i,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi_o,
    input  logic        mosi_oe,
    input  logic        valid,
    input  logic        done,
    input  logic        err,
    input  logic [7:0]  data,
    output logic        miso,
    output logic        io0,
    output logic        io0_en,
    output int          n_chk,
    output int          n_bad
);
    int   exp_addr = 0, exp_len = 0, exp_div = 2, idx = 0, rc = 0, run = 0, gapc = 0;
    bit   exp_dual = 0, exp_err = 0, had = 0;
    logic prev_s = (CPOL != 0), prev_c = 1'b1;
    logic [31:0] hdr = '0;
    logic [7:0]  b;
    int   k;

    initial begin
        n_chk  = 0;
        n_bad  = 0;
        miso   = 1'b0;
        io0    = 1'b0;
        io0_en = 1'b0;
    end

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 37 + (a >> 8) * 11) ^ 8'hA5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s (cpol=%0d) actual=%0h expected=%0h", req, CPOL, act_v, exp_v);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            prev_s = (CPOL != 0);
            prev_c = 1'b1;
            miso   <= 1'b0;
            io0_en <= 1'b0;
        end else begin
            if (start_i && !busy_i) begin
                exp_addr = int'(addr_i);
                exp_len  = int'(len_i);
                exp_dual = dual_i;
                exp_div  = (div_i < 4'd2) ? 2 : int'(div_i);
                exp_err  = (len_i == 0) || (int'(addr_i) + int'(len_i) > 65536);
                idx      = 0;
            end
            if (prev_c && !cs_n) begin
                chk(sclk == (CPOL != 0), "R2 clock level at select fall", int'(sclk), CPOL);
                chk(!exp_err, "R9 bus activity on refused request", 1, 0);
                if (had) chk(gapc >= 2, "R8 deselect gap", gapc, 2);
                rc  = 0;
                hdr = '0;
                run = 0;
            end
            if (!prev_c && cs_n) begin
                chk(sclk == (CPOL != 0), "R2 clock level at select rise", int'(sclk), CPOL);
                chk(rc == 40 + exp_len * (exp_dual ? 4 : 8), "R4 rising edge count",
                    rc, 40 + exp_len * (exp_dual ? 4 : 8));
                gapc = 0;
                had  = 1;
                miso   <= 1'b0;
                io0_en <= 1'b0;
            end
            if (cs_n) begin
                gapc = gapc + 1;
                run  = 0;
            end else begin
                if (!prev_s && sclk) begin
                    if (rc < 32) hdr = {hdr[30:0], mosi_o};
                    rc = rc + 1;
                    if (rc == 32) begin
                        chk(hdr[31:24] == (exp_dual ? 8'h3B : 8'h0B), "R3 opcode",
                            int'(hdr[31:24]), exp_dual ? 32'h3B : 32'h0B);
                        chk(hdr[23:0] == 24'(exp_addr), "R3 address", int'(hdr[23:0]), exp_addr);
                    end
                end
                if (prev_s && !sclk && rc >= 40) begin
                    k = rc - 40;
                    if (exp_dual) begin
                        b = mem_byte(exp_addr + k / 4);
                        miso   <= b[7 - 2 * (k % 4)];
                        io0    <= b[6 - 2 * (k % 4)];
                        io0_en <= 1'b1;
                    end else begin
                        b = mem_byte(exp_addr + k / 8);
                        miso <= b[7 - (k % 8)];
                    end
                end
                if (sclk == prev_s) begin
                    run = run + 1;
                end else begin
                    if (prev_s) chk(run == exp_div, "R10 high half length", run, exp_div);
                    run = 1;
                end
                if (io0_en) chk(!mosi_oe, "R7 line contention", int'(mosi_oe), 0);
            end
            if (valid) begin
                chk(data == mem_byte(exp_addr + idx), exp_dual ? "R6 two-line byte" : "R5 one-line byte",
                    int'(data), int'(mem_byte(exp_addr + idx)));
                chk(mosi_oe == !exp_dual, "R7 drive enable during data", int'(mosi_oe), int'(!exp_dual));
                idx = idx + 1;
            end
            if (done) begin
                chk(err == exp_err, "R9 error flag", int'(err), int'(exp_err));
                if (!exp_err) chk(idx == exp_len, "R11 bytes delivered", idx, exp_len);
            end
            prev_s = sclk;
            prev_c = cs_n;
        end
    end
endmodule

module sfrd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] addr = '0;
    logic [16:0] len = '0;
    logic        dual = 1'b0;
    logic [3:0]  div = 4'd2;

    logic        busy0, valid0, done0, err0, sclk0, csn0, mosi0, oe0, m0_miso, m0_io0, m0_en;
    logic        busy3, valid3, done3, err3, sclk3, csn3, mosi3, oe3, m3_miso, m3_io0, m3_en;
    logic [7:0]  data0, data3;
    int          mc0, mb0, mc3, mb3;
    int          n_chk = 0, n_bad = 0;
    int          dc0 = 0, dc3 = 0;

    always #2.5 clk = ~clk;

    sfrd_ctrl #(.CPOL(0)) u_sfrd_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
        .dual_i(dual), .div_i(div), .busy_o(busy0), .data_o(data0), .valid_o(valid0),
        .done_o(done0), .err_o(err0), .sclk_o(sclk0), .cs_n_o(csn0), .mosi_o(mosi0),
        .mosi_oe_o(oe0), .mosi_i(m0_en ? m0_io0 : 1'b0), .miso_i(m0_miso)
    );

    sfrd_ctrl #(.CPOL(1)) u_sfrd_ctrl_m3 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
        .dual_i(dual), .div_i(div), .busy_o(busy3), .data_o(data3), .valid_o(valid3),
        .done_o(done3), .err_o(err3), .sclk_o(sclk3), .cs_n_o(csn3), .mosi_o(mosi3),
        .mosi_oe_o(oe3), .mosi_i(m3_en ? m3_io0 : 1'b0), .miso_i(m3_miso)
    );

    sfrd_flash_model #(.CPOL(0)) u_model0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy0), .addr_i(addr),
        .len_i(len), .dual_i(dual), .div_i(div), .sclk(sclk0), .cs_n(csn0),
        .mosi_o(mosi0), .mosi_oe(oe0), .valid(valid0), .done(done0), .err(err0),
        .data(data0), .miso(m0_miso), .io0(m0_io0), .io0_en(m0_en), .n_chk(mc0), .n_bad(mb0)
    );

    sfrd_flash_model #(.CPOL(1)) u_model3 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy3), .addr_i(addr),
        .len_i(len), .dual_i(dual), .div_i(div), .sclk(sclk3), .cs_n(csn3),
        .mosi_o(mosi3), .mosi_oe(oe3), .valid(valid3), .done(done3), .err(err3),
        .data(data3), .miso(m3_miso), .io0(m3_io0), .io0_en(m3_en), .n_chk(mc3), .n_bad(mb3)
    );

    always @(posedge clk) begin
        if (done0) dc0 <= dc0 + 1;
        if (done3) dc3 <= dc3 + 1;
    end

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    task automatic xfer(input logic [23:0] a, input int l, input logic d,
                        input logic [3:0] dv, input bit poke);
        int b0;
        int b3;
        int t;
        b0 = dc0;
        b3 = dc3;
        t  = 0;
        @(negedge clk);
        addr  = a;
        len   = 17'(l);
        dual  = d;
        div   = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (30) @(negedge clk);
            check(busy0 && busy3, "R11 busy before second start", int'({busy0, busy3}), 3);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while ((dc0 == b0 || dc3 == b3) && t < 50000) begin
            @(negedge clk);
            t = t + 1;
        end
        check(t < 50000, "R8 request completion", t, 0);
        @(negedge clk);
        check(dc0 == b0 + 1 && dc3 == b3 + 1, "R8 one done per request",
              dc0 - b0 + dc3 - b3, 2);
    endtask

    initial begin
        #950000;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk + mc0 + mc3 + 1, n_bad + mb0 + mb3 + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(csn0 && csn3, "R1 select idle", int'({csn0, csn3}), 3);
        check(sclk0 == 1'b0, "R1 clock idle mode 0", int'(sclk0), 0);
        check(sclk3 == 1'b1, "R1 clock idle mode 3", int'(sclk3), 1);
        check(!busy0 && !busy3 && !valid0 && !valid3, "R1 status low", 0, 0);
        check(!done0 && !done3, "R1 done low", int'({done0, done3}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        xfer(24'h000010, 5, 1'b0, 4'd2, 1'b0);   // R5 R3 R4
        xfer(24'h001234, 6, 1'b1, 4'd3, 1'b0);   // R6 R7
        xfer(24'h00FFFF, 1, 1'b1, 4'd0, 1'b0);   // R9 boundary, R10 clamp
        xfer(24'h00FFF0, 16, 1'b0, 4'd5, 1'b0);  // R9 last byte at top
        xfer(24'h00FFFE, 3, 1'b0, 4'd2, 1'b0);   // R9 crossing
        check(csn0 && csn3, "R9 select stayed high", int'({csn0, csn3}), 3);
        xfer(24'h000100, 0, 1'b1, 4'd2, 1'b0);   // R9 zero length
        xfer(24'h000200, 4, 1'b0, 4'd2, 1'b1);   // R11 start while busy
        xfer(24'h000800, 3, 1'b1, 4'd2, 1'b0);   // R8 gap
        xfer(24'h000803, 2, 1'b1, 4'd4, 1'b0);   // R8 back-to-back

        check(mc0 > 40 && mc3 > 40, "R4 model activity", mc0 + mc3, 80);
        $display("  test done: total=%0d bad=%0d", n_chk + mc0 + mc3, n_bad + mb0 + mb3);
        $finish;
    end
endmodule